// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel hung off a free-running timer counter that lives elsewhere. It watches the counter value, the counter's count direction and its overflow tick. Depending on a 2-bit mode it does one of four jobs:

- It timestamps edges arriving on an external pin.
- It raises an event and moves its pin when the counter reaches a programmed value.
- It produces an edge-aligned pulse train.
- It produces a symmetric, center-aligned pulse train.

The channel owns its value register. Software loads the register, and an input capture overwrites it. A sticky event flag reports every channel event, and what counts as an event depends on the mode. Software clears the flag only by reading it while it is set and then writing zero. A stray zero write therefore cannot discard an event that software has not yet seen.

The pin input is asynchronous and passes through a configurable synchronizer before edge detection. The pin output is a register.

Top module: `tmr_chan`

## Requirements
- R1: In capture mode (mode=00), sel selects the capture edge: 00 none, 01 rising, 10 falling, 11 both. Only the selected edge sets the flag.
- R2: A selected edge loads the cnt_val value present at the third rising clock after the pin change into ch_val, and the flag shows it at that same clock. After two clocks the flag is still clear.
- R3: In output compare (mode=01), the flag is set on the clock where cnt_val equals ch_val.
- R4: In output compare, sel picks the pin action on a match: 00 none, 01 toggle, 10 drive 0, 11 drive 1. Without a match the pin holds.
- R5: In edge PWM (mode=10), the pin goes active on the clock of cnt_ovf and inactive on the clock of a match, with overflow taking priority. The active level is 1 when sel[0]=0 and 0 when sel[0]=1. The flag is set on the match. For a counter 0..N, the pin is active during counts 0..ch_val.
- R6: In center PWM (mode=11), a match while cnt_down=1 makes the pin active and a match while cnt_down=0 makes it inactive, with the same polarity rule as R5. The flag is set on both matches, giving two events per period.
- R7: A clock with flag_wr0 high clears the flag only if flag_rd was sampled high while the flag was set, after the previous zero write. A new event on the clearing clock keeps the flag set.
- R8: A synchronous reset (rst=1) clears pin_out, flag and ch_val.
- R9: val_wr loads val_wdata into ch_val on the next clock, unless a capture occurs on that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CW | Shared counter value |
| cnt_down | input | 1 | Counter direction, 1 = counting down |
| cnt_ovf | input | 1 | Counter period tick (terminal count) |
| mode | input | 2 | 00 capture, 01 compare, 10 edge PWM, 11 center PWM |
| sel | input | 2 | Edge select / pin action / polarity |
| val_wr | input | 1 | Load strobe for the channel value |
| val_wdata | input | CW | Value to load |
| flag_rd | input | 1 | Software read of the event flag |
| flag_wr0 | input | 1 | Software write of zero to the event flag |
| pin_in | input | 1 | Asynchronous capture pin |
| pin_out | output | 1 | Channel pin output |
| flag | output | 1 | Sticky channel event flag |
| ch_val | output | CW | Channel value register |

## Verification
A synchronizer with a wrong depth or a wrong edge decode shows up within three clocks of a pin change, either as a flag at the wrong clock or as the wrong counter stamp in ch_val. A wrong pin-state update shows up one clock after the offending match or overflow. Because the bench checks the pin on every count of several full periods, a duty cycle that is off by one count, an inverted polarity or a swapped direction is reported within one period. A clear that does not require the prior read is caught within two clocks of the zero write.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  typedef enum logic [1:0] {
    MODE_CAPT = 2'b00,
    MODE_CMP  = 2'b01,
    MODE_EPWM = 2'b10,
    MODE_CPWM = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ACT_NONE   = 2'b00;
  localparam logic [1:0] ACT_TOGGLE = 2'b01;
  localparam logic [1:0] ACT_LOW    = 2'b10;
  localparam logic [1:0] ACT_HIGH   = 2'b11;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       edge_hit
);
  localparam int LAST = STAGES - 1;

  // sh[0] is the first synchronizer stage; sh[STAGES] holds the previous synced value
  logic [STAGES:0] sh;
  logic            rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise     = sh[LAST] & ~sh[STAGES];
  assign fall     = ~sh[LAST] & sh[STAGES];
  assign edge_hit = en & ((sel[0] & rise) | (sel[1] & fall));

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |-> !edge_hit);
  assert_edge_source_R1: assert property (@(posedge clk) disable iff (rst)
    edge_hit |-> (sh[LAST] != sh[STAGES]));
endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rd,
  input  logic wr0,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_evt)            flag <= 1'b1;
      else if (wr0 && armed)  flag <= 1'b0;
      if (wr0)                armed <= 1'b0;
      else if (rd && flag)    armed <= 1'b1;
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);
  assert_unarmed_write_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && wr0 && !armed) |=> flag);
  assert_two_step_R7: assert property (@(posedge clk) disable iff (rst)
    (wr0 && armed && !set_evt) |=> !flag);
endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
  import tmr_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tmr_mode_e mode,
  input  logic [1:0] sel,
  input  logic      match,
  input  logic      cnt_down,
  input  logic      cnt_ovf,
  output logic      pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
    end else begin
      unique case (mode)
        MODE_CMP: begin
          if (match) begin
            case (sel)
              ACT_TOGGLE: pin <= ~pin;
              ACT_LOW:    pin <= 1'b0;
              ACT_HIGH:   pin <= 1'b1;
              default:    pin <= pin;
            endcase
          end
        end
        MODE_EPWM: begin
          if (cnt_ovf)    pin <= ~sel[0];
          else if (match) pin <= sel[0];
        end
        MODE_CPWM: begin
          if (match) pin <= cnt_down ? ~sel[0] : sel[0];
        end
        default: pin <= pin;
      endcase
    end
  end

  assert_cmp_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CMP && (!match || sel == ACT_NONE)) |=> (pin == $past(pin)));
  assert_epwm_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_EPWM && cnt_ovf) |=> (pin == !$past(sel[0])));
  assert_cpwm_up_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CPWM && match && !cnt_down) |=> (pin == $past(sel[0])));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_down,
  input  logic          cnt_ovf,
  input  logic [1:0]    mode,
  input  logic [1:0]    sel,
  input  logic          val_wr,
  input  logic [CW-1:0] val_wdata,
  input  logic          flag_rd,
  input  logic          flag_wr0,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          flag,
  output logic [CW-1:0] ch_val
);
  tmr_mode_e mode_e;
  logic      capt_en, cap_hit, match, set_evt;

  assign mode_e  = tmr_mode_e'(mode);
  assign capt_en = (mode_e == MODE_CAPT);
  assign match   = !capt_en && (cnt_val == ch_val);
  assign set_evt = cap_hit | match;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .en(capt_en), .sel(sel), .edge_hit(cap_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)         ch_val <= '0;
    else if (cap_hit) ch_val <= cnt_val;
    else if (val_wr)  ch_val <= val_wdata;
  end

  tmr_flag_ctl u_flag (
    .clk(clk), .rst(rst), .set_evt(set_evt), .rd(flag_rd), .wr0(flag_wr0), .flag(flag)
  );

  tmr_pin_ctl u_pin (
    .clk(clk), .rst(rst), .mode(mode_e), .sel(sel), .match(match),
    .cnt_down(cnt_down), .cnt_ovf(cnt_ovf), .pin(pin_out)
  );

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> (ch_val == $past(cnt_val)));
  assert_match_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (!capt_en && cnt_val == ch_val) |=> flag);
  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    (val_wr && !cap_hit) |=> (ch_val == $past(val_wdata)));
endmodule

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
  localparam int CW = 16;
  localparam int M  = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_down = 1'b0, cnt_ovf = 1'b0;
  logic [1:0]    mode = 2'b00, sel = 2'b00;
  logic          val_wr = 1'b0;
  logic [CW-1:0] val_wdata = '0;
  logic          flag_rd = 1'b0, flag_wr0 = 1'b0, pin_in = 1'b0;
  logic          pin_out, flag;
  logic [CW-1:0] ch_val;

  int checks = 0, fails = 0;

  tmr_chan #(.CW(CW), .SYNC_STAGES(2)) i_tmr_chan (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down), .cnt_ovf(cnt_ovf),
    .mode(mode), .sel(sel), .val_wr(val_wr), .val_wdata(val_wdata),
    .flag_rd(flag_rd), .flag_wr0(flag_wr0), .pin_in(pin_in),
    .pin_out(pin_out), .flag(flag), .ch_val(ch_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clr_flag();
    flag_rd = 1'b1; step();
    flag_rd = 1'b0; flag_wr0 = 1'b1; step();
    flag_wr0 = 1'b0;
  endtask

  task automatic load_val(input int v);
    val_wr = 1'b1; val_wdata = CW'(v); step();
    val_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p0, expp, prev, base, evts, st;
    bit hit, act;
    repeat (3) step();
    // R8 reset state
    chk(pin_out == 1'b0, "R8 pin_out", int'(pin_out), 0);
    chk(flag == 1'b0, "R8 flag", int'(flag), 0);
    chk(ch_val == '0, "R8 ch_val", int'(ch_val), 0);
    rst = 1'b0;
    step();

    // R9 load
    mode = 2'b01; sel = 2'b00; cnt_val = 1000;
    load_val(5);
    chk(ch_val == 5, "R9 load", int'(ch_val), 5);

    // R3/R4 output compare sweep over all actions
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); cnt_val = 1000;
      clr_flag(); step();
      p0 = int'(pin_out);
      chk(flag == 1'b0, "R3 flag clear before match", int'(flag), 0);
      expp = (s == 0) ? p0 : (s == 1) ? 1 - p0 : (s == 2) ? 0 : 1;
      for (int c = 0; c < 10; c++) begin
        cnt_val = CW'(c); step();
        if (c < 5) begin
          chk(pin_out == p0[0], "R4 hold before match", int'(pin_out), p0);
          chk(flag == 1'b0, "R3 no early flag", int'(flag), 0);
        end else begin
          chk(pin_out == expp[0], "R4 action", int'(pin_out), expp);
          chk(flag == 1'b1, "R3 match flag", int'(flag), 1);
        end
      end
      cnt_val = 1000;
    end

    // R7 two-step clear
    sel = 2'b00; cnt_val = 1000; clr_flag();
    cnt_val = 5; step(); cnt_val = 1000; step();
    chk(flag == 1'b1, "R7 flag set", int'(flag), 1);
    flag_wr0 = 1'b1; step(); flag_wr0 = 1'b0; step();
    chk(flag == 1'b1, "R7 write without read", int'(flag), 1);
    flag_rd = 1'b1; step(); flag_rd = 1'b0; flag_wr0 = 1'b1; step(); flag_wr0 = 1'b0;
    chk(flag == 1'b0, "R7 read then write clears", int'(flag), 0);
    cnt_val = 5; step(); cnt_val = 1000;
    flag_rd = 1'b1; step(); flag_rd = 1'b0; flag_wr0 = 1'b1; cnt_val = 5; step();
    flag_wr0 = 1'b0; cnt_val = 1000;
    chk(flag == 1'b1, "R7 event wins over clear", int'(flag), 1);
    clr_flag();
    chk(flag == 1'b0, "R7 final clear", int'(flag), 0);

    // R1/R2 capture: every edge select against rising and falling edges
    mode = 2'b00;
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 2; e++) begin
        sel = 2'(s); pin_in = e[0]; cnt_val = 1000;
        repeat (5) step();
        clr_flag(); step();
        prev = int'(ch_val);
        base = 200 + s * 16 + e * 4;
        hit  = (e == 0) ? sel[0] : sel[1];
        pin_in = ~e[0]; cnt_val = CW'(base); step();
        cnt_val = CW'(base + 1); step();
        chk(flag == 1'b0, "R2 latency lower bound", int'(flag), 0);
        cnt_val = CW'(base + 2); step();
        chk(flag == hit, "R1 edge select", int'(flag), int'(hit));
        chk(int'(ch_val) == (hit ? base + 2 : prev), "R2 captured stamp",
            int'(ch_val), hit ? base + 2 : prev);
        cnt_val = 1000;
      end
    end

    // R5 edge PWM: duty sweep, both polarities, checked every count
    mode = 2'b10;
    for (int pol = 0; pol < 2; pol++) begin
      for (int v = 0; v < 10; v++) begin
        sel = pol[0] ? 2'b01 : 2'b10;
        cnt_val = 1000; cnt_ovf = 1'b0;
        load_val(v); clr_flag();
        for (int k = 0; k < 3 * (M + 1); k++) begin
          int cn;
          cn = k % (M + 1);
          if (k >= M + 1) begin
            act = (cn <= v);
            chk(pin_out == (act ^ pol[0]), "R5 edge pwm level",
                int'(pin_out), int'(act ^ pol[0]));
          end
          cnt_val = CW'(cn); cnt_ovf = (cn == M); step();
        end
        cnt_val = 1000; cnt_ovf = 1'b0; step();
        chk(flag == (v <= M), "R5 match flag", int'(flag), int'(v <= M));
      end
    end

    // R6 center PWM: duty sweep, both polarities
    mode = 2'b11;
    for (int pol = 0; pol < 2; pol++) begin
      for (int v = 0; v < M; v++) begin
        sel = {1'b0, pol[0]};
        cnt_val = 1000; cnt_down = 1'b0; cnt_ovf = 1'b0;
        load_val(v);
        for (int k = 0; k < 3 * 2 * M; k++) begin
          int i, c;
          bit d;
          i = k % (2 * M);
          d = (i > M);
          c = d ? 2 * M - i : i;
          if (k >= 2 * M) begin
            act = (v == 0) ? 1'b0 : (d ? (c < v) : (c <= v));
            chk(pin_out == (act ^ pol[0]), "R6 center pwm level",
                int'(pin_out), int'(act ^ pol[0]));
          end
          cnt_val = CW'(c); cnt_down = d; cnt_ovf = (i == M); step();
        end
      end
    end

    // R6 two flag events per period
    sel = 2'b00; cnt_val = 1000; cnt_down = 1'b0; cnt_ovf = 1'b0;
    load_val(3); clr_flag();
    evts = 0; st = 0;
    for (int k = 0; k < 2 * 2 * M + 3; k++) begin
      int i, c;
      bit d;
      i = k % (2 * M);
      d = (i > M);
      c = d ? 2 * M - i : i;
      if (st == 0 && flag) begin
        evts++; flag_rd = 1'b1; st = 1;
      end else if (st == 1) begin
        flag_rd = 1'b0; flag_wr0 = 1'b1; st = 2;
      end else if (st == 2) begin
        flag_wr0 = 1'b0; st = 0;
      end
      if (k < 2 * 2 * M) begin
        cnt_val = CW'(c); cnt_down = d; cnt_ovf = (i == M);
      end else begin
        cnt_val = 1000; cnt_down = 1'b0; cnt_ovf = 1'b0;
      end
      step();
    end
    flag_rd = 1'b0; flag_wr0 = 1'b0;
    chk(evts == 4, "R6 events per two periods", evts, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule